// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the bus-side slave of a byte-wide serial memory with a 13-bit address space. It samples the two-wire bus through a synchronizer on a fast system clock and finds start and stop conditions. It decodes the address word that follows a start and pulls SDA low through an output enable. The enable is used to acknowledge bytes and to shift read data out.

Received write bytes leave on a one-cycle strobe that carries the target address and the data. A separate page/commit block takes these bytes. That block also receives a pulse when the transfer ends with a stop, and it reports its internal write cycle back on a busy input. While busy is high the engine does not acknowledge its own address, so a master can poll until the write completes.

Reads come from an external array through a combinational address/data pair. A current-address counter serves current-address reads, random reads and sequential reads.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the output enable is low and the current-address counter is zero, so a current-address read as the first transfer returns the byte at address 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start seen in any state abandons the transfer in progress and decodes the next byte as an address word.
- R3: The first byte after a start arrives MSB first. Bits 7..4 must equal 1010, bits 3..1 must equal `sel_i[2:0]`, and bit 0 selects read (1) or write (0). On any mismatch the block stays released and waits for the next start.
- R4: The block acknowledges a received byte by enabling the pull-down for exactly the ninth SCL clock. It never pulls SDA while the master is sending data bits, and its enable changes only while SCL is low, except when a start or stop clears it.
- R5: A write sends two address bytes after the address word, high byte first. Each is acknowledged. The top 3 bits of the high byte are ignored, and the counter takes {high[4:0], low}.
- R6: Each write data byte yields one `wr_stb_o` pulse with the current address and the byte, and is acknowledged. The address then steps within its 32-byte page, so the low 5 bits wrap from 31 to 0 and the upper bits hold.
- R7: `wr_done_o` pulses once on a stop that ends a transfer in which at least one data byte was strobed. A stop after an address-only or polling transfer gives no pulse.
- R8: A read shifts the byte at the current address out MSB first, and the counter steps by one. An acknowledge of 0 from the master sends the next byte.
- R9: After a read byte answered with 1, the block keeps SDA released on every further clock until a start or stop.
- R10: Sequential reading wraps from address 0x1FFF to 0x0000 and continues.
- R11: A current-address read uses the last accessed address plus one, with the page wrap of R6 after a write.
- R12: While `busy_i` is high at the end of the address word, the block does not acknowledge it, for either value of the R/W bit. Once busy is low, it acknowledges.
- R13: A random read, made of a write address word, two address bytes, a repeated start and a read address word, returns the byte at the given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sel_i | input | 3 | Strapped select value matched against address word bits 3..1 |
| busy_i | input | 1 | Internal write cycle in progress (from commit block) |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| rd_addr_o | output | 13 | Current address presented to the array |
| wr_stb_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 13 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed write byte |
| wr_done_o | output | 1 | One-cycle pulse: write transfer closed by stop |

## Verification
The bench aims at the page roll-over: four bytes are written from offset 30 of a page. A counter that carried into the upper bits would strobe addresses in the next page. It reads across the top of the array to catch a counter that saturates or stops at 0x1FFF. It polls while busy is high to show an acknowledge given too early. It aborts a transfer halfway through an address byte with a start, which a design that ignored mid-byte starts would misread as data. After a not-acknowledge, further clocks must find the line released. A design that kept shifting data would pull SDA low there.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_ACK,
    S_RDAT,
    S_RACK,
    S_RNXT,
    S_RWAIT
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  // synchronizer chains and one history stage, idle-high at reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC_N-2:0], scl_i};
      sda_p <= {sda_p[SYNC_N-2:0], sda_i};
      scl_q <= scl_p[SYNC_N-1];
      sda_q <= sda_p[SYNC_N-1];
    end
  end

  assign scl_s     = scl_p[SYNC_N-1];
  assign sda_s     = sda_p[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int AW     = 13,
  parameter int PAGE_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc_seq,
  input  logic          inc_page,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_n;

  always_comb begin
    addr_n = addr;
    if (ld)
      addr_n = ld_val;
    else if (inc_seq)
      addr_n = addr + 1'b1;
    else if (inc_page)
      addr_n = {addr[AW-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_n;
  end

  // R6: a page step never touches the bits above the page offset
  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc_page) && !$past(ld) && !$past(inc_seq)) |-> (addr[AW-1:PAGE_W] == $past(addr[AW-1:PAGE_W])));

  // R10: a sequential step advances by one modulo the array size
  p_seq_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc_seq) && !$past(ld)) |-> (addr == AW'($past(addr) + 1)));
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
  import tw_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [2:0]    sel_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe,
  output logic          ld,
  output logic [AW-1:0] ld_val,
  output logic          inc_seq,
  output logic          inc_page,
  output logic          wr_stb,
  output logic [7:0]    wr_data,
  output logic          wr_done
);
  localparam int HI_W = AW - 8;

  tw_state_e st, st_n, aft, aft_n;
  logic [2:0]      cnt, cnt_n;
  logic [7:0]      sh, sh_n;
  logic [HI_W-1:0] hi, hi_n;
  logic            oe_n, ph, ph_n, wany, wany_n;
  logic [7:0]      byte_in;
  logic            do_load;

  assign byte_in = {sh[6:0], sda_s};
  assign wr_data = byte_in;

  always_comb begin
    st_n = st; aft_n = aft; cnt_n = cnt; sh_n = sh; hi_n = hi;
    oe_n = sda_oe; ph_n = ph; wany_n = wany;
    ld = 1'b0; ld_val = {hi, byte_in}; inc_seq = 1'b0; inc_page = 1'b0;
    wr_stb = 1'b0; wr_done = 1'b0; do_load = 1'b0;
    if (stop_det) begin
      st_n = S_IDLE; oe_n = 1'b0; wr_done = wany; wany_n = 1'b0;
    end else if (start_det) begin
      st_n = S_DEV; cnt_n = '0; oe_n = 1'b0; wany_n = 1'b0;
    end else begin
      unique case (st)
        S_IDLE, S_RWAIT: ;
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          if (scl_rise) begin
            sh_n  = byte_in;
            cnt_n = cnt + 3'd1;
            if (cnt == 3'd7) begin
              ph_n = 1'b0;
              st_n = S_ACK;
              unique case (st)
                S_DEV: begin
                  if (byte_in[7:4] != DEV_CODE || byte_in[3:1] != sel_i || busy_i)
                    st_n = S_IDLE;
                  aft_n = byte_in[0] ? S_RDAT : S_AHI;
                end
                S_AHI: begin
                  hi_n  = byte_in[HI_W-1:0];
                  aft_n = S_ALO;
                end
                S_ALO: begin
                  ld    = 1'b1;
                  aft_n = S_WDAT;
                end
                default: begin
                  wr_stb   = 1'b1;
                  inc_page = 1'b1;
                  wany_n   = 1'b1;
                  aft_n    = S_WDAT;
                end
              endcase
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (!ph) begin
              oe_n = 1'b1;
              ph_n = 1'b1;
            end else if (aft == S_RDAT) begin
              do_load = 1'b1;
            end else begin
              oe_n  = 1'b0;
              cnt_n = '0;
              st_n  = aft;
            end
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 3'd1;
            if (cnt == 3'd7) begin
              st_n = S_RACK;
              ph_n = 1'b0;
            end
          end else if (scl_fall) begin
            oe_n = ~sh[7];
            sh_n = {sh[6:0], 1'b0};
          end
        end
        S_RACK: begin
          if (scl_fall && !ph) begin
            oe_n = 1'b0;
            ph_n = 1'b1;
          end else if (scl_rise && ph) begin
            st_n = sda_s ? S_RWAIT : S_RNXT;
          end
        end
        S_RNXT: begin
          if (scl_fall) do_load = 1'b1;
        end
        default: st_n = S_IDLE;
      endcase
      if (do_load) begin
        oe_n    = ~rd_data_i[7];
        sh_n    = {rd_data_i[6:0], 1'b0};
        inc_seq = 1'b1;
        cnt_n   = '0;
        st_n    = S_RDAT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; aft <= S_IDLE; cnt <= '0; sh <= '0; hi <= '0;
      sda_oe <= 1'b0; ph <= 1'b0; wany <= 1'b0;
    end else begin
      st <= st_n; aft <= aft_n; cnt <= cnt_n; sh <= sh_n; hi <= hi_n;
      sda_oe <= oe_n; ph <= ph_n; wany <= wany_n;
    end
  end

  // R4: the pull-down only moves while SCL is low, or when a start/stop clears it
  p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R3: standby never pulls the line
  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R12: an address word is only taken into the ack phase with busy low
  p_busy_noack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && $past(st) == S_DEV) |-> !$past(busy_i));

  // R9: after a not-acknowledge the line stays released
  p_wait_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RWAIT) |-> !sda_oe);
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter int AW     = 13,
  parameter int PAGE_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    sel_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_done_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ld, inc_seq, inc_page;
  logic [AW-1:0] ld_val, cur_addr;

  tw_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tw_slave_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sel_i(sel_i), .busy_i(busy_i), .rd_data_i(rd_data_i), .sda_oe(sda_oe_o),
    .ld(ld), .ld_val(ld_val), .inc_seq(inc_seq), .inc_page(inc_page),
    .wr_stb(wr_stb_o), .wr_data(wr_data_o), .wr_done(wr_done_o)
  );

  tw_addr_ctr #(.AW(AW), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val),
    .inc_seq(inc_seq), .inc_page(inc_page), .addr(cur_addr)
  );

  assign rd_addr_o = cur_addr;
  assign wr_addr_o = cur_addr;
endmodule

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0, mst_drv = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sda_oe, wr_stb, wr_done, sda_bus;
  logic [12:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  int n_chk = 0, n_fail = 0, n_done = 0, busy_cnt = 0, cyc = 0;
  int exp_wa[$], exp_wd[$];
  logic [7:0] mem [int];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  tw_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sel_i(3'b101),
    .busy_i(busy), .rd_data_i(rd_data), .sda_oe_o(sda_oe), .rd_addr_o(rd_addr),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_done_o(wr_done)
  );

  function automatic logic [7:0] rdm(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // array and commit-block model, plus per-clock release check (R4)
  always @(negedge clk) begin
    cyc++;
    rd_data <= rdm(int'(rd_addr));
    if (mst_drv) chk("R4 released during master bits", int'(sda_oe), 0);
    if (wr_stb) begin
      if (exp_wa.size() == 0) chk("R6 unexpected strobe", int'(wr_addr), -1);
      else begin
        chk("R6 strobe address", int'(wr_addr), exp_wa.pop_front());
        chk("R6 strobe data", int'(wr_data), exp_wd.pop_front());
      end
      mem[int'(wr_addr)] = wr_data;
    end
    if (wr_done) begin n_done++; busy_cnt = 300; end
    else if (busy_cnt > 0) busy_cnt--;
    busy <= (busy_cnt > 0);
    if (cyc > 150000) begin
      chk("watchdog", 1, 0);
      summary();
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; wt(5); scl = 1'b1; wt(5); sda_m = 1'b0; wt(5); scl = 1'b0; wt(5);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(5); scl = 1'b1; wt(5); sda_m = 1'b1; wt(10);
  endtask

  task automatic send_bit(input logic b);
    mst_drv = 1'b1; sda_m = b; wt(5); scl = 1'b1; wt(10); scl = 1'b0; mst_drv = 1'b0; wt(5);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(5); scl = 1'b1; wt(5);
    chk(req, int'(sda_bus), ack ? 0 : 1);
    wt(5); scl = 1'b0; wt(5);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
    logic [7:0] v = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(5); scl = 1'b1; wt(5); v = {v[6:0], sda_bus}; wt(5); scl = 1'b0; wt(5);
    end
    chk(req, int'(v), int'(exp));
    sda_m = mack; wt(5); scl = 1'b1; wt(10); scl = 1'b0; wt(2); sda_m = 1'b1; wt(3);
  endtask

  initial begin
    wt(4); rst_n = 1'b1; wt(4);
    chk("R1 reset enable low", int'(sda_oe), 0);
    chk("R1 reset counter", int'(rd_addr), 0);

    // R1/R8/R11: current read after reset returns address 0
    do_start(); send_byte(8'hAB, 1, "R3 read word ack");
    recv_byte(rdm(0), 1'b1, "R1 first current read"); do_stop();

    // R3: wrong code, wrong select
    do_start(); send_byte(8'h5B, 0, "R3 bad code nack"); do_stop();
    do_start(); send_byte(8'hA9, 0, "R3 bad select nack"); do_stop();

    // R5/R6/R7: byte write, upper address bits ignored
    exp_wa.push_back(13'h0310); exp_wd.push_back(8'h5A);
    do_start(); send_byte(8'hAA, 1, "R4 write word ack");
    send_byte(8'hE3, 1, "R5 high address ack"); send_byte(8'h10, 1, "R5 low address ack");
    send_byte(8'h5A, 1, "R6 data ack"); do_stop();
    chk("R7 done after write", n_done, 1);

    // R12: poll while busy, then after
    do_start(); send_byte(8'hAA, 0, "R12 busy nack"); do_stop();
    wt(400);
    do_start(); send_byte(8'hAA, 1, "R12 ready ack"); do_stop();
    chk("R7 no done for poll", n_done, 1);

    // R6: page write wrapping inside the page
    exp_wa.push_back(13'h041E); exp_wd.push_back(8'h11);
    exp_wa.push_back(13'h041F); exp_wd.push_back(8'h22);
    exp_wa.push_back(13'h0400); exp_wd.push_back(8'h33);
    exp_wa.push_back(13'h0401); exp_wd.push_back(8'h44);
    do_start(); send_byte(8'hAA, 1, "R6 word ack");
    send_byte(8'h04, 1, "R5 ack"); send_byte(8'h1E, 1, "R5 ack");
    send_byte(8'h11, 1, "R6 ack"); send_byte(8'h22, 1, "R6 ack");
    send_byte(8'h33, 1, "R6 ack"); send_byte(8'h44, 1, "R6 ack"); do_stop();
    chk("R7 done after page", n_done, 2);
    wt(400);

    // R11: current read follows the page-wrapped address
    do_start(); send_byte(8'hAB, 1, "R11 word ack");
    recv_byte(rdm(13'h0402), 1'b1, "R11 current after page write"); do_stop();

    // R13/R8/R9: random read, sequential step, then released wait
    do_start(); send_byte(8'hAA, 1, "R13 ack"); send_byte(8'h03, 1, "R13 ack");
    send_byte(8'h10, 1, "R13 ack");
    do_start(); send_byte(8'hAB, 1, "R13 read word ack");
    recv_byte(8'h5A, 1'b0, "R13 random read data");
    recv_byte(rdm(13'h0311), 1'b1, "R8 sequential next");
    for (int k = 0; k < 3; k++) begin
      wt(5); scl = 1'b1; wt(5); chk("R9 line released after nack", int'(sda_bus), 1);
      wt(5); scl = 1'b0; wt(5);
    end
    do_stop();

    // R10: wrap at top of array
    do_start(); send_byte(8'hAA, 1, "R10 ack"); send_byte(8'h1F, 1, "R10 ack");
    send_byte(8'hFF, 1, "R10 ack");
    do_start(); send_byte(8'hAB, 1, "R10 read ack");
    recv_byte(rdm(13'h1FFF), 1'b0, "R10 last location");
    recv_byte(rdm(0), 1'b1, "R10 wrapped to zero"); do_stop();

    // R2: start in the middle of an address byte restarts decoding
    do_start(); send_byte(8'hAA, 1, "R2 ack");
    for (int k = 0; k < 4; k++) send_bit(1'b0);
    do_start(); send_byte(8'hAB, 1, "R2 restart word ack");
    recv_byte(rdm(1), 1'b1, "R2 read after abort"); do_stop();
    chk("R7 done count final", n_done, 2);
    chk("R6 all strobes seen", exp_wa.size(), 0);

    wt(20);
    summary();
  end
endmodule